// File: doc/BRIEF.md
# Banked ADC Result Buffer

This block collects the 12-bit results of a sixteen-channel conversion scan so that software can pick up the whole scan in one burst after it ends, instead of servicing every conversion. Storage is four byte-wide FIFOs of eight entries each, arranged as two banks. Each bank holds a low-byte FIFO and a high-byte FIFO. Each result is split across the two FIFOs of the active bank. The upper bank receives the first half of a descending scan (channels 15 down to 8) and the lower bank receives the second half (channels 7 down to 0).

The bank choice follows bit 3 of the external channel counter. That bit is re-registered only on the acquisition-done strobe, so the bank can never change in the same cycle as a capture. A result is written on the capture strobe into the two FIFOs of the active bank, but only while those FIFOs have room. When the lower bank fills, the scan is complete and an interrupt is raised. Software then drains both banks. Each read pops the low and high FIFOs of one bank together. The interrupt drops once all four FIFOs are empty.

Top module: `adc_bank_buffer`

## Requirements
- R1: With the registered bank bit at 1 a capture writes the upper bank (FIFO indices 2 = low byte, 3 = high byte); with it at 0 the lower bank (indices 0 = low, 1 = high).
- R2: A captured result is stored as result[7:0] in the low-byte FIFO and as {4'b0, result[11:8]} in the high-byte FIFO.
- R3: The bank bit takes chan_cnt_i[3] on a cycle with acq_done_i high and holds otherwise; changing chan_cnt_i without the strobe does not move captures to the other bank. It resets to 1.
- R4: A capture into a bank whose FIFOs hold 8 entries is dropped and leaves the stored contents unchanged.
- R5: full_o[i] is 1 exactly when FIFO i holds 8 entries; the two FIFOs of a bank are always full together.
- R6: irq_o rises one cycle after both lower-bank FIFOs become full, and not while only the upper bank is full.
- R7: irq_o stays high until all four FIFOs are empty and falls one cycle after that.
- R8: rd_i pops the low and high FIFOs of the bank picked by rd_bank_i (1 = upper), in write order; the popped bytes appear on rd_lo_o and rd_hi_o in the next cycle.
- R9: A read of an empty bank returns zero on both read outputs and sets underflow_o, which then stays set until reset.
- R10: After reset all FIFOs are empty, full_o is 0, and irq_o, underflow_o and the read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_done_i | input | 1 | Acquisition-done strobe; samples the bank bit |
| chan_cnt_i | input | 4 | Current channel counter value |
| cap_i | input | 1 | Capture strobe for result_i |
| result_i | input | 12 | Conversion result |
| rd_i | input | 1 | Read request, pops one entry pair |
| rd_bank_i | input | 1 | Bank to read, 1 = upper, 0 = lower |
| rd_lo_o | output | 8 | Low byte of the last read |
| rd_hi_o | output | 8 | High byte of the last read |
| full_o | output | 4 | Full flag per FIFO |
| underflow_o | output | 1 | Sticky empty-read flag |
| irq_o | output | 1 | Scan-complete interrupt |

## Verification
A complete descending scan of sixteen distinct results shows that bank routing, byte splitting and FIFO order are correct. It also shows that the interrupt waits for the lower bank rather than the first full bank. An extra capture into the full lower bank separates a correct drop from an overwrite or pointer slip. A capture made after the counter changed without a strobe separates a registered bank bit from a direct use of the counter. A short interleaved pattern of lower, upper and lower captures shows that the banks keep separate order. Reads past the end of a bank show the zero data and the sticky underflow flag.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
  parameter int RES_W      = 12;
  parameter int BYTE_W     = 8;
  parameter int FIFO_DEPTH = 8;
  parameter int CNT_W      = 4;
  parameter int BANK_BIT   = 3;
  parameter int NUM_BANKS  = 2;
  parameter int LANES      = 2;  // low byte, high byte
  localparam int NUM_FIFOS = NUM_BANKS * LANES;
endpackage

// File: rtl/abuf_byte_fifo.sv
module abuf_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/abuf_bank_sel.sv
module abuf_bank_sel #(
  parameter int CNT_W    = 4,
  parameter int BANK_BIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acq_done_i,
  input  logic [CNT_W-1:0] chan_cnt_i,
  output logic             bank_up_o,
  output logic [1:0]       bank_en_o
);
  logic up_q;

  // counter idles at all ones, so the upper bank is active first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         up_q <= 1'b1;
    else if (acq_done_i) up_q <= chan_cnt_i[BANK_BIT];
  end

  assign bank_up_o = up_q;
  assign bank_en_o = {up_q, ~up_q};
endmodule

// File: rtl/adc_bank_buffer.sv
module adc_bank_buffer
  import abuf_pkg::*;
#(
  parameter int P_RES_W  = RES_W,
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_DEPTH  = FIFO_DEPTH,
  parameter int P_CNT_W  = CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acq_done_i,
  input  logic [P_CNT_W-1:0]  chan_cnt_i,
  input  logic                cap_i,
  input  logic [P_RES_W-1:0]  result_i,
  input  logic                rd_i,
  input  logic                rd_bank_i,
  output logic [P_BYTE_W-1:0] rd_lo_o,
  output logic [P_BYTE_W-1:0] rd_hi_o,
  output logic [NUM_FIFOS-1:0] full_o,
  output logic                underflow_o,
  output logic                irq_o
);
  localparam int HI_W = P_RES_W - P_BYTE_W;

  logic [1:0]            bank_en;
  logic                  bank_up;
  logic [NUM_FIFOS-1:0]  fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [P_BYTE_W-1:0]   fifo_head [NUM_FIFOS];
  logic [P_BYTE_W-1:0]   lane_data [LANES];
  logic [P_BYTE_W-1:0]   rd_lo_q, rd_hi_q;
  logic                  underflow_q, irq_q;
  logic                  sel_empty;
  int unsigned           sel_lo, sel_hi;

  abuf_bank_sel #(.CNT_W(P_CNT_W), .BANK_BIT(BANK_BIT)) u_bank_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acq_done_i (acq_done_i),
    .chan_cnt_i (chan_cnt_i),
    .bank_up_o  (bank_up),
    .bank_en_o  (bank_en)
  );

  assign lane_data[0] = result_i[P_BYTE_W-1:0];
  assign lane_data[1] = P_BYTE_W'(result_i[P_RES_W-1:P_BYTE_W]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int IDX = b * LANES + k;
      assign fifo_push[IDX] = cap_i & bank_en[b] & ~fifo_full[IDX];
      assign fifo_pop[IDX]  = rd_i & (rd_bank_i == 1'(b));
      abuf_byte_fifo #(.W(P_BYTE_W), .DEPTH(P_DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (fifo_push[IDX]),
        .data_i  (lane_data[k]),
        .pop_i   (fifo_pop[IDX]),
        .head_o  (fifo_head[IDX]),
        .full_o  (fifo_full[IDX]),
        .empty_o (fifo_empty[IDX])
      );
    end
  end

  always_comb begin
    sel_lo    = rd_bank_i ? 2 : 0;
    sel_hi    = sel_lo + 1;
    sel_empty = fifo_empty[sel_lo] | fifo_empty[sel_hi];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lo_q     <= '0;
      rd_hi_q     <= '0;
      underflow_q <= 1'b0;
    end else if (rd_i) begin
      rd_lo_q <= sel_empty ? '0 : fifo_head[sel_lo];
      rd_hi_q <= sel_empty ? '0 : fifo_head[sel_hi];
      if (sel_empty) underflow_q <= 1'b1;
    end
  end

  // scan complete once the lower bank (second half) is full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         irq_q <= 1'b0;
    else if (&fifo_empty)                irq_q <= 1'b0;
    else if (fifo_full[0] & fifo_full[1]) irq_q <= 1'b1;
  end

  assign rd_lo_o     = rd_lo_q;
  assign rd_hi_o     = rd_hi_q;
  assign full_o      = fifo_full;
  assign underflow_o = underflow_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/adc_bank_buffer_chk.sv
module adc_bank_buffer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acq_done_i,
  input logic [3:0] chan_cnt_i,
  input logic       rd_i,
  input logic       rd_bank_i,
  input logic [3:0] full_i,
  input logic [3:0] empty_i,
  input logic       bank_up_i,
  input logic       underflow_i,
  input logic       irq_i
);
  a_r3_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_done_i |=> $stable(bank_up_i));
  a_r3_bank_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_done_i |=> (bank_up_i == $past(chan_cnt_i[3])));
  a_r5_pair_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i[0] == full_i[1]) && (full_i[2] == full_i[3]));
  a_r4_lower_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i[0] && !(rd_i && !rd_bank_i) |=> full_i[0]);
  a_r4_upper_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i[2] && !(rd_i && rd_bank_i) |=> full_i[2]);
  a_r6_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i[0] && full_i[1] |=> irq_i);
  a_r7_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&empty_i) |=> !irq_i);
  a_r9_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_i |=> underflow_i);
endmodule

bind adc_bank_buffer adc_bank_buffer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acq_done_i  (acq_done_i),
  .chan_cnt_i  (chan_cnt_i),
  .rd_i        (rd_i),
  .rd_bank_i   (rd_bank_i),
  .full_i      (fifo_full),
  .empty_i     (fifo_empty),
  .bank_up_i   (bank_up),
  .underflow_i (underflow_q),
  .irq_i       (irq_q)
);

// File: tb/adc_bank_buffer_test.sv
module adc_bank_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acq = 1'b0, cap = 1'b0, rd = 1'b0, rd_bank = 1'b0;
  logic [3:0]  cnt = 4'hF;
  logic [11:0] res = '0;
  logic [7:0]  rd_lo, rd_hi;
  logic [3:0]  full;
  logic        uf, irq;

  int checks = 0, errors = 0;
  logic model_up = 1'b1;
  logic [11:0] q_up[$], q_lo[$];
  logic pend = 1'b0, pend_bank = 1'b0;

  always #10 clk = ~clk;

  adc_bank_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .acq_done_i(acq), .chan_cnt_i(cnt),
    .cap_i(cap), .result_i(res), .rd_i(rd), .rd_bank_i(rd_bank),
    .rd_lo_o(rd_lo), .rd_hi_o(rd_hi), .full_o(full),
    .underflow_o(uf), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_acq(input logic [3:0] c);
    @(negedge clk); cnt = c; acq = 1'b1;
    @(negedge clk); acq = 1'b0;
    model_up = c[3];
  endtask

  // driver: pushes the expected entry into the bank model
  task automatic do_cap(input logic [11:0] v);
    @(negedge clk); res = v; cap = 1'b1;
    if (model_up) begin if (q_up.size() < 8) q_up.push_back(v); end
    else          begin if (q_lo.size() < 8) q_lo.push_back(v); end
    @(negedge clk); cap = 1'b0;
  endtask

  task automatic do_rd(input logic b);
    @(negedge clk); rd = 1'b1; rd_bank = b;
    @(negedge clk); rd = 1'b0;
  endtask

  always @(posedge clk) begin
    pend      <= rd;
    pend_bank <= rd_bank;
  end

  // monitor: pops the expected entry and compares the read outputs (R8, R2, R1, R9)
  always @(negedge clk) begin
    if (pend) begin
      logic [11:0] e;
      logic        emp;
      emp = pend_bank ? (q_up.size() == 0) : (q_lo.size() == 0);
      if (emp) begin
        chk(rd_lo == 8'h00 && rd_hi == 8'h00, "R9 empty read data", {rd_hi, rd_lo}, 0);
        chk(uf == 1'b1, "R9 underflow set", uf, 1);
      end else begin
        e = pend_bank ? q_up.pop_front() : q_lo.pop_front();
        chk(rd_lo == e[7:0], "R2/R8 low byte", rd_lo, e[7:0]);
        chk(rd_hi == {4'b0, e[11:8]}, "R2/R8 high byte (R1 bank)", rd_hi, {4'b0, e[11:8]});
      end
    end
  end

  function automatic logic [11:0] val(input int c);
    return 12'((c * 299 + 37) % 4096);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(full == 4'b0000, "R10 full", full, 0);
    chk(irq == 1'b0 && uf == 1'b0, "R10 irq/underflow", {irq, uf}, 0);
    chk(rd_lo == 0 && rd_hi == 0, "R10 read data", {rd_hi, rd_lo}, 0);
    rst_n = 1'b1;

    // full descending scan
    for (int c = 15; c >= 0; c--) begin
      do_acq(4'(c));
      do_cap(val(c));
      if (c == 8) begin
        chk(full == 4'b1100, "R5 upper full", full, 4'hC);
        @(negedge clk);
        chk(irq == 1'b0, "R6 no irq on upper only", irq, 0);
      end
    end
    chk(full == 4'b1111, "R5 all full", full, 4'hF);
    @(negedge clk);
    chk(irq == 1'b1, "R6 irq after lower full", irq, 1);

    // R4 capture into full lower bank is dropped
    do_acq(4'd0);
    do_cap(12'hFFF);
    chk(full == 4'b1111, "R4 still full", full, 4'hF);

    for (int i = 0; i < 8; i++) do_rd(1'b1);
    @(negedge clk);
    chk(full == 4'b0011, "R5 upper drained", full, 4'h3);
    chk(irq == 1'b1, "R7 irq held while lower not empty", irq, 1);
    for (int i = 0; i < 8; i++) do_rd(1'b0);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq cleared when empty", irq, 0);
    chk(uf == 1'b0, "R9 no underflow yet", uf, 0);

    // R9 empty read
    do_rd(1'b0);
    repeat (3) @(negedge clk);
    chk(uf == 1'b1, "R9 underflow sticky", uf, 1);

    // R3 counter change without strobe does not move bank
    do_acq(4'd12);
    @(negedge clk); cnt = 4'd3;
    do_cap(12'hA5C);
    chk(full == 4'b0000, "R3 single entry", full, 0);
    do_rd(1'b1);
    do_rd(1'b0);

    // interleaved banks: lower, upper, lower
    do_acq(4'd5);  do_cap(12'h123);
    do_acq(4'd9);  do_cap(12'h9E7);
    do_acq(4'd2);  do_cap(12'h456);
    do_rd(1'b0);
    do_rd(1'b1);
    do_rd(1'b0);
    do_rd(1'b1);
    repeat (2) @(negedge clk);
    chk(q_up.size() == 0 && q_lo.size() == 0, "R1 model drained", q_up.size() + q_lo.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule